// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the management end of a Fast Ethernet physical-layer device. A station manager clocks serial frames into it on MDC over a single bidirectional MDIO data line. Here that line is split into a sampled input, a driven output and an output enable. Each frame names a 5-bit PHY address and a 5-bit register address. The slave compares the PHY address with strap inputs. On a match it raises a select output and then takes 16 bits from the manager or returns 16 bits to it. Two registers exist. The control register drives six mode outputs: soft reset, loopback, power down, isolate, full duplex and collision test. The status register reports fixed ability bits and a link bit that latches low.

A single frame sequencer walks through named states. S_IDLE counts preamble ones. S_START checks the second start bit. S_OPCODE takes two opcode bits. S_PHYAD takes the PHY address. S_REGAD takes the register address. S_TURN covers the two turnaround bits. S_DATA carries 16 data bits. The transitions are:
- S_IDLE to S_START on a zero after a full preamble.
- S_START to S_OPCODE on a one. A zero returns to S_IDLE.
- S_OPCODE to S_PHYAD on a legal opcode. Any other opcode returns to S_IDLE.
- S_PHYAD to S_REGAD on an address match. A mismatch returns to S_IDLE.
- S_REGAD to S_TURN after five bits.
- S_TURN to S_DATA after two bits.
- S_DATA to S_IDLE after the sixteenth bit.

The sequencer updates on every rising MDC edge.

Top module: `mgmt_serial_slave`

## Requirements
- R1: A frame is accepted only if its start bit is preceded by at least 32 consecutive ones sampled on MDC rising edges. A frame after a shorter run has no effect. Every frame needs its own preamble.
- R2: After the preamble the start field must be 0 then 1. The opcode must be 1,0 (read) or 0,1 (write). Any other opcode abandons the frame with no effect. The PHY address and the register address follow, 5 bits each, most significant bit first.
- R3: addr_sel goes high only when the PHY address equals phy_addr_strap. It is visible from the bit period after the last PHY address bit until the frame ends. A frame with a different PHY address never drives MDIO and changes no register.
- R4: On a matching read, mdio_oe stays low during the first turnaround bit. During the second it is high with mdio_out 0. The 16 data bits follow, bit 15 first, each updated on an MDC rising edge. mdio_oe falls at the edge that samples the last data bit.
- R5: A matching write to register 0 with data bit 15 clear updates the control fields at the edge of the last data bit. The field positions are: bit 14 loopback, bit 11 power down, bit 10 isolate, bit 8 full duplex, bit 7 collision test. A write to any other register has no effect.
- R6: Control register reads return bit 13 as 1, bits 12, 9 and 6..0 as 0, and the other bits as the current fields.
- R7: A write to register 0 with bit 15 set drives ctl_reset high for exactly one MDC cycle, starting at the last data edge. The field values are left unchanged during that cycle. At the next edge all fields return to their defaults, and bit 15 reads 0 afterwards.
- R8: While rst_hw is high, loopback, power down, full duplex, collision test and ctl_reset are 0. Isolate equals the inverse of local_mode.
- R9: Status register reads return bits 14 and 13 as 1, bit 2 as the link latch, and every other bit as 0.
- R10: The link latch is 0 after reset and clears at any edge where link_fail is high. It is set again only by a status read that sees link_fail low at its first turnaround edge. The read itself returns the value held before that edge.
- R11: Register addresses 2 to 31 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state moves on its rising edge |
| rst_hw | input | 1 | Asynchronous active-high reset of both registers and the sequencer |
| phy_addr_strap | input | 5 | PHY address this slave answers to |
| local_mode | input | 1 | Strap; low makes isolate come up set |
| link_fail | input | 1 | High while the link is down, sampled on MDC |
| mdio_in | input | 1 | Sampled value of the serial data line |
| mdio_out | output | 1 | Value driven onto the serial data line |
| mdio_oe | output | 1 | High while the slave drives the line |
| addr_sel | output | 1 | High during a frame whose PHY address matched |
| ctl_reset | output | 1 | One-cycle soft reset pulse |
| ctl_loopback | output | 1 | Loopback mode |
| ctl_power_down | output | 1 | Power-down mode |
| ctl_isolate | output | 1 | Isolate from the MAC interface |
| ctl_full_duplex | output | 1 | Full-duplex mode |
| ctl_col_test | output | 1 | Collision test mode |

## Verification
The assertions assume that mdio_in and link_fail are synchronous to the rising MDC edge and settled around it. They also assume rst_hw is high from time zero until the first frame. The bench changes every input only on the falling MDC edge and keeps MDC running. Between frames it holds the line low, so the preamble run seen by the slave is exactly the one each scenario intends.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
    localparam int MD_ADDR_W  = 5;
    localparam int MD_DATA_W  = 16;
    localparam int MD_PRE_LEN = 32;

    // control register bit positions
    localparam int CB_RESET = 15;
    localparam int CB_LOOP  = 14;
    localparam int CB_SPEED = 13;
    localparam int CB_PDOWN = 11;
    localparam int CB_ISO   = 10;
    localparam int CB_FDX   = 8;
    localparam int CB_COLT  = 7;

    // status register bit positions
    localparam int SB_FDX_ABL = 14;
    localparam int SB_HDX_ABL = 13;
    localparam int SB_LINK    = 2;

    localparam logic [MD_ADDR_W-1:0] REG_CTRL = 5'd0;
    localparam logic [MD_ADDR_W-1:0] REG_STAT = 5'd1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_OPCODE,
        S_PHYAD,
        S_REGAD,
        S_TURN,
        S_DATA
    } frame_state_t;
endpackage

// File: rtl/mgmt_frame_fsm.sv
module mgmt_frame_fsm
    import mgmt_pkg::*;
#(
    parameter int ADDR_W  = MD_ADDR_W,
    parameter int DATA_W  = MD_DATA_W,
    parameter int PRE_LEN = MD_PRE_LEN
) (
    input  logic              mdc,
    input  logic              rst_hw,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              mdio_in,
    input  logic [DATA_W-1:0] rd_data,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              addr_sel,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam int PRE_W = $clog2(PRE_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_TWO = CNT_W'(1);
    localparam logic [CNT_W-1:0] LAST_ADR = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_DAT = CNT_W'(DATA_W - 1);
    localparam logic [PRE_W-1:0] PRE_FULL = PRE_W'(PRE_LEN);

    frame_state_t      state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [PRE_W-1:0]  pre_cnt;
    logic [DATA_W-1:0] sh_in;
    logic [DATA_W-1:0] sh_out;
    logic              is_rd_q;
    logic              pre_full;
    logic              op_ok;
    logic              phy_hit;

    assign pre_full = (pre_cnt == PRE_FULL);
    assign op_ok    = (sh_in[0] != mdio_in);
    assign phy_hit  = ({sh_in[ADDR_W-2:0], mdio_in} == phy_addr);

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (!mdio_in && pre_full) state_d = S_START;
            S_START:  state_d = mdio_in ? S_OPCODE : S_IDLE;
            S_OPCODE: if (bit_cnt == LAST_TWO) state_d = op_ok ? S_PHYAD : S_IDLE;
            S_PHYAD:  if (bit_cnt == LAST_ADR) state_d = phy_hit ? S_REGAD : S_IDLE;
            S_REGAD:  if (bit_cnt == LAST_ADR) state_d = S_TURN;
            S_TURN:   if (bit_cnt == LAST_TWO) state_d = S_DATA;
            S_DATA:   if (bit_cnt == LAST_DAT) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register and field bookkeeping
    always_ff @(posedge mdc or posedge rst_hw) begin
        if (rst_hw) begin
            state_q  <= S_IDLE;
            bit_cnt  <= '0;
            pre_cnt  <= '0;
            sh_in    <= '0;
            is_rd_q  <= 1'b0;
            reg_addr <= '0;
        end else begin
            state_q <= state_d;
            sh_in   <= {sh_in[DATA_W-2:0], mdio_in};
            if (state_q == S_IDLE || state_d != state_q) bit_cnt <= '0;
            else bit_cnt <= bit_cnt + CNT_W'(1);
            if (state_q == S_IDLE && mdio_in) begin
                if (!pre_full) pre_cnt <= pre_cnt + PRE_W'(1);
            end else begin
                pre_cnt <= '0;
            end
            if (state_q == S_OPCODE && bit_cnt == LAST_TWO)
                is_rd_q <= sh_in[0] && !mdio_in;
            if (state_q == S_REGAD && bit_cnt == LAST_ADR)
                reg_addr <= {sh_in[ADDR_W-2:0], mdio_in};
        end
    end

    assign rd_stb  = (state_q == S_TURN) && (bit_cnt == '0) && is_rd_q;
    assign wr_stb  = (state_q == S_DATA) && (bit_cnt == LAST_DAT) && !is_rd_q;
    assign wr_data = {sh_in[DATA_W-2:0], mdio_in};

    // output register: select, line enable and serial read data
    always_ff @(posedge mdc or posedge rst_hw) begin
        if (rst_hw) begin
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b0;
            sh_out   <= '0;
            addr_sel <= 1'b0;
        end else begin
            if (state_q == S_PHYAD && bit_cnt == LAST_ADR && phy_hit) addr_sel <= 1'b1;
            else if (state_d == S_IDLE) addr_sel <= 1'b0;

            if (rd_stb) begin
                mdio_oe  <= 1'b1;
                mdio_out <= 1'b0;
                sh_out   <= rd_data;
            end else if (state_q == S_TURN && bit_cnt == LAST_TWO && mdio_oe) begin
                mdio_out <= sh_out[DATA_W-1];
                sh_out   <= {sh_out[DATA_W-2:0], 1'b0};
            end else if (state_q == S_DATA && mdio_oe) begin
                if (bit_cnt == LAST_DAT) begin
                    mdio_oe  <= 1'b0;
                    mdio_out <= 1'b0;
                end else begin
                    mdio_out <= sh_out[DATA_W-1];
                    sh_out   <= {sh_out[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    // R3
    oe_needs_sel_chk: assert property (@(posedge mdc) disable iff (rst_hw)
        !addr_sel |-> !mdio_oe);
    // R4
    ta_drives_zero_chk: assert property (@(posedge mdc) disable iff (rst_hw)
        $rose(mdio_oe) |-> !mdio_out);
    // R4
    release_after_data_chk: assert property (@(posedge mdc) disable iff (rst_hw)
        (state_q == S_DATA && bit_cnt == LAST_DAT) |=> !mdio_oe);
    // R1
    idle_never_drives_chk: assert property (@(posedge mdc) disable iff (rst_hw)
        (state_q == S_IDLE) |-> !mdio_oe);
endmodule

// File: rtl/mgmt_ctrl_reg.sv
module mgmt_ctrl_reg
    import mgmt_pkg::*;
#(
    parameter int DATA_W = MD_DATA_W
) (
    input  logic              mdc,
    input  logic              rst_hw,
    input  logic              local_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              ctl_reset,
    output logic              ctl_loopback,
    output logic              ctl_power_down,
    output logic              ctl_isolate,
    output logic              ctl_full_duplex,
    output logic              ctl_col_test
);
    logic rst_pend;

    always_ff @(posedge mdc or posedge rst_hw) begin
        if (rst_hw) begin
            rst_pend        <= 1'b0;
            ctl_loopback    <= 1'b0;
            ctl_power_down  <= 1'b0;
            ctl_isolate     <= !local_mode;
            ctl_full_duplex <= 1'b0;
            ctl_col_test    <= 1'b0;
        end else if (rst_pend) begin
            rst_pend        <= 1'b0;
            ctl_loopback    <= 1'b0;
            ctl_power_down  <= 1'b0;
            ctl_isolate     <= !local_mode;
            ctl_full_duplex <= 1'b0;
            ctl_col_test    <= 1'b0;
        end else if (wr_en) begin
            if (wr_data[CB_RESET]) begin
                rst_pend <= 1'b1;
            end else begin
                ctl_loopback    <= wr_data[CB_LOOP];
                ctl_power_down  <= wr_data[CB_PDOWN];
                ctl_isolate     <= wr_data[CB_ISO];
                ctl_full_duplex <= wr_data[CB_FDX];
                ctl_col_test    <= wr_data[CB_COLT];
            end
        end
    end

    assign ctl_reset = rst_pend;

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[CB_RESET] = rst_pend;
        ctrl_word[CB_LOOP]  = ctl_loopback;
        ctrl_word[CB_SPEED] = 1'b1;
        ctrl_word[CB_PDOWN] = ctl_power_down;
        ctrl_word[CB_ISO]   = ctl_isolate;
        ctrl_word[CB_FDX]   = ctl_full_duplex;
        ctrl_word[CB_COLT]  = ctl_col_test;
    end

    // R7
    soft_reset_pulse_chk: assert property (@(posedge mdc) disable iff (rst_hw)
        ctl_reset |=> !ctl_reset);
    // R7
    soft_reset_defaults_chk: assert property (@(posedge mdc) disable iff (rst_hw)
        ctl_reset |=> (!ctl_loopback && !ctl_power_down && !ctl_full_duplex
                       && !ctl_col_test && (ctl_isolate == !local_mode)));
endmodule

// File: rtl/mgmt_status_reg.sv
module mgmt_status_reg
    import mgmt_pkg::*;
#(
    parameter int DATA_W = MD_DATA_W
) (
    input  logic              mdc,
    input  logic              rst_hw,
    input  logic              link_fail,
    input  logic              rd_en,
    output logic [DATA_W-1:0] stat_word
);
    logic link_q;

    always_ff @(posedge mdc or posedge rst_hw) begin
        if (rst_hw) link_q <= 1'b0;
        else if (link_fail) link_q <= 1'b0;
        else if (rd_en) link_q <= 1'b1;
    end

    always_comb begin
        stat_word             = '0;
        stat_word[SB_FDX_ABL] = 1'b1;
        stat_word[SB_HDX_ABL] = 1'b1;
        stat_word[SB_LINK]    = link_q;
    end

    // R10
    link_clears_chk: assert property (@(posedge mdc) disable iff (rst_hw)
        link_fail |=> !stat_word[SB_LINK]);
    // R10
    link_holds_low_chk: assert property (@(posedge mdc) disable iff (rst_hw)
        (!stat_word[SB_LINK] && !rd_en) |=> !stat_word[SB_LINK]);
endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave
    import mgmt_pkg::*;
#(
    parameter int ADDR_W  = MD_ADDR_W,
    parameter int DATA_W  = MD_DATA_W,
    parameter int PRE_LEN = MD_PRE_LEN
) (
    input  logic              mdc,
    input  logic              rst_hw,
    input  logic [ADDR_W-1:0] phy_addr_strap,
    input  logic              local_mode,
    input  logic              link_fail,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              addr_sel,
    output logic              ctl_reset,
    output logic              ctl_loopback,
    output logic              ctl_power_down,
    output logic              ctl_isolate,
    output logic              ctl_full_duplex,
    output logic              ctl_col_test
);
    logic [ADDR_W-1:0] reg_addr;
    logic              rd_stb, wr_stb;
    logic [DATA_W-1:0] wr_data, rd_data, ctrl_word, stat_word;

    mgmt_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) fsm_i (
        .mdc      (mdc),
        .rst_hw   (rst_hw),
        .phy_addr (phy_addr_strap),
        .mdio_in  (mdio_in),
        .rd_data  (rd_data),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .addr_sel (addr_sel),
        .reg_addr (reg_addr),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data)
    );

    mgmt_ctrl_reg #(.DATA_W(DATA_W)) ctrl_i (
        .mdc             (mdc),
        .rst_hw          (rst_hw),
        .local_mode      (local_mode),
        .wr_en           (wr_stb && (reg_addr == REG_CTRL)),
        .wr_data         (wr_data),
        .ctrl_word       (ctrl_word),
        .ctl_reset       (ctl_reset),
        .ctl_loopback    (ctl_loopback),
        .ctl_power_down  (ctl_power_down),
        .ctl_isolate     (ctl_isolate),
        .ctl_full_duplex (ctl_full_duplex),
        .ctl_col_test    (ctl_col_test)
    );

    mgmt_status_reg #(.DATA_W(DATA_W)) stat_i (
        .mdc       (mdc),
        .rst_hw    (rst_hw),
        .link_fail (link_fail),
        .rd_en     (rd_stb && (reg_addr == REG_STAT)),
        .stat_word (stat_word)
    );

    always_comb begin
        if (reg_addr == REG_CTRL)      rd_data = ctrl_word;
        else if (reg_addr == REG_STAT) rd_data = stat_word;
        else                           rd_data = '0;
    end
endmodule

// File: tb/mgmt_serial_slave_tb.sv
module mgmt_serial_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] MY_PHY = 5'h0B;

    logic mdc = 1'b0;
    logic rst_hw = 1'b1;
    logic [4:0] phy_addr_strap = MY_PHY;
    logic local_mode = 1'b0;
    logic link_fail = 1'b0;
    logic mdio_in = 1'b0;
    logic mdio_out, mdio_oe, addr_sel;
    logic ctl_reset, ctl_loopback, ctl_power_down, ctl_isolate, ctl_full_duplex, ctl_col_test;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    mgmt_serial_slave dut_i (
        .mdc(mdc), .rst_hw(rst_hw), .phy_addr_strap(phy_addr_strap),
        .local_mode(local_mode), .link_fail(link_fail), .mdio_in(mdio_in),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .addr_sel(addr_sel),
        .ctl_reset(ctl_reset), .ctl_loopback(ctl_loopback),
        .ctl_power_down(ctl_power_down), .ctl_isolate(ctl_isolate),
        .ctl_full_duplex(ctl_full_duplex), .ctl_col_test(ctl_col_test)
    );

    always #(CLK_PERIOD/2) mdc = ~mdc;

    function automatic logic [5:0] ctl_vec();
        return {ctl_reset, ctl_loopback, ctl_power_down, ctl_isolate, ctl_full_duplex, ctl_col_test};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge mdc);
        mdio_in = b;
    endtask

    task automatic run_frame(input int pre_n, input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] wd, input bit sample,
                             output logic [15:0] rdv, output bit ta_ok, output bit drove,
                             output bit sel_seen);
        rdv = '0; ta_ok = 1; drove = 0; sel_seen = 0;
        for (int i = 0; i < pre_n; i++) put_bit(1'b1);
        put_bit(1'b0); put_bit(1'b1);
        put_bit(op[1]); put_bit(op[0]);
        for (int i = 4; i >= 0; i--) put_bit(phy[i]);
        for (int i = 4; i >= 0; i--) begin
            put_bit(rg[i]);
            if (i == 4) sel_seen = (addr_sel === 1'b1);
            drove |= (mdio_oe === 1'b1);
        end
        if (sample) begin
            put_bit(1'b0);
            ta_ok = ta_ok && (mdio_oe === 1'b0);
            drove |= (mdio_oe === 1'b1);
            put_bit(1'b0);
            ta_ok = ta_ok && (mdio_oe === 1'b1) && (mdio_out === 1'b0);
            drove |= (mdio_oe === 1'b1);
            for (int i = 15; i >= 0; i--) begin
                put_bit(1'b0);
                rdv[i] = mdio_out;
                ta_ok = ta_ok && (mdio_oe === 1'b1);
                drove |= (mdio_oe === 1'b1);
            end
        end else begin
            put_bit(1'b1); put_bit(1'b0);
            for (int i = 15; i >= 0; i--) begin
                put_bit(wd[i]);
                drove |= (mdio_oe === 1'b1);
            end
        end
        put_bit(1'b0);
        if (sample) ta_ok = ta_ok && (mdio_oe === 1'b0);
    endtask

    task automatic do_write(input logic [4:0] rg, input logic [15:0] wd);
        logic [15:0] r; bit t, d, s;
        run_frame(32, 2'b01, MY_PHY, rg, wd, 0, r, t, d, s);
    endtask

    task automatic do_read(input logic [4:0] rg, input logic [15:0] exp, input string req);
        logic [15:0] r; bit t, d, s;
        run_frame(32, 2'b10, MY_PHY, rg, 16'h0, 1, r, t, d, s);
        check(req, r, exp);
    endtask

    task automatic t_reset();
        local_mode = 1'b0; rst_hw = 1'b1;
        repeat (2) @(negedge mdc);
        check("R8 isolate set with remote strap", ctl_vec(), 6'b000100);
        local_mode = 1'b1;
        repeat (2) @(negedge mdc);
        rst_hw = 1'b0;
        @(negedge mdc);
        check("R8 defaults with local strap", ctl_vec(), 6'b000000);
        check("R3 idle select and enable", {addr_sel, mdio_oe}, 2'b00);
    endtask

    task automatic t_read_ctrl();
        logic [15:0] r; bit t, d, s;
        run_frame(32, 2'b10, MY_PHY, 5'd0, 16'h0, 1, r, t, d, s);
        check("R6 control default read", r, 16'h2000);
        check("R4 turnaround and release", t, 1);
        check("R3 select on match", s, 1);
    endtask

    task automatic t_status();
        do_read(5'd1, 16'h6000, "R10 latch zero after reset");
        do_read(5'd1, 16'h6004, "R9 status with link up");
        @(negedge mdc); link_fail = 1'b1;
        @(negedge mdc); link_fail = 1'b0;
        do_read(5'd1, 16'h6000, "R10 cleared by link fail pulse");
        do_read(5'd1, 16'h6004, "R10 re-set after read");
        link_fail = 1'b1;
        do_read(5'd1, 16'h6000, "R10 read during fail");
        link_fail = 1'b0;
        do_read(5'd1, 16'h6000, "R10 no re-set when read saw fail");
        do_read(5'd1, 16'h6004, "R10 re-set by later read");
    endtask

    task automatic t_write_ctrl();
        do_write(5'd0, 16'h7FFF);
        check("R5 fields after write", ctl_vec(), 6'b011111);
        do_read(5'd0, 16'h6D80, "R6 control read masks");
    endtask

    task automatic t_other_regs();
        do_write(5'd5, 16'hFFFF);
        do_write(5'd1, 16'h0000);
        check("R5 other writes keep fields", ctl_vec(), 6'b011111);
        do_read(5'd5, 16'h0000, "R11 address 5 reads zero");
        do_read(5'd31, 16'h0000, "R11 address 31 reads zero");
        do_read(5'd1, 16'h6004, "R5 status not writable");
    endtask

    task automatic t_wrong_phy();
        logic [15:0] r; bit t, d, s;
        run_frame(32, 2'b01, 5'h0C, 5'd0, 16'h0000, 0, r, t, d, s);
        check("R3 mismatch write ignored", ctl_vec(), 6'b011111);
        check("R3 no select on mismatch", s, 0);
        run_frame(32, 2'b10, 5'h1B, 5'd0, 16'h0000, 1, r, t, d, s);
        check("R3 mismatch read never drives", d, 0);
    endtask

    task automatic t_preamble_opcode();
        logic [15:0] r; bit t, d, s;
        run_frame(31, 2'b01, MY_PHY, 5'd0, 16'h0000, 0, r, t, d, s);
        check("R1 short preamble ignored", ctl_vec(), 6'b011111);
        run_frame(32, 2'b11, MY_PHY, 5'd0, 16'h0000, 0, r, t, d, s);
        check("R2 opcode 11 ignored", ctl_vec(), 6'b011111);
        run_frame(32, 2'b00, MY_PHY, 5'd0, 16'h0000, 0, r, t, d, s);
        check("R2 opcode 00 ignored", ctl_vec(), 6'b011111);
        run_frame(32, 2'b01, MY_PHY, 5'd0, 16'h0100, 0, r, t, d, s);
        check("R1 full preamble accepted", ctl_vec(), 6'b000010);
    endtask

    task automatic t_soft_reset();
        do_write(5'd0, 16'h4D80);
        check("R5 mode write", ctl_vec(), 6'b011111);
        do_write(5'd0, 16'h8000);
        check("R7 pulse with fields held", ctl_vec(), 6'b111111);
        @(negedge mdc);
        check("R7 defaults after pulse", ctl_vec(), 6'b000000);
        do_read(5'd0, 16'h2000, "R7 reset bit self-cleared");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_read_ctrl();
        t_status();
        t_write_ctrl();
        t_other_regs();
        t_wrong_phy();
        t_preamble_opcode();
        t_soft_reset();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule